// File: doc/BRIEF.md
# Serial EEPROM Block Read Controller

This controller sits on the master side of a four-wire serial EEPROM link made of chip select, serial clock, data to the device and data from the device. A one-cycle host request carries a start address and a word count. The controller then fetches that many consecutive 16-bit words. Each word gets its own chip-select transaction: a one-period select lead-in, a three-bit read command, the address, and seventeen clocked-in bits. The first of those seventeen bits is a dummy zero and is dropped.

The serial clock is made from the system clock. Its low and high phases are set in system cycles by parameters, chosen to meet the device minimums of 250 ns low and 750 ns high. Each word is handed to the host with a one-cycle strobe and its position in the block. The controller keeps a 16-bit running sum of every word except the last. When the last word arrives, it raises a done pulse and a flag that tells whether the block passes its checksum.

Top module: `eeprom_block_reader`

## Requirements
- R1: A start request is ignored while `busy` is high, and a request with `word_count` equal to 0 is also ignored. In both cases no transaction begins and the running block keeps its address and count.
- R2: Each word transaction raises `ser_cs` for one serial clock period with `ser_mosi` low. It then sends the bits 1, 1, 0 (a start bit followed by read opcode 10), and then the ADDR_W-bit word address, most significant bit first.
- R3: After the address, 17 bits are sampled from `ser_miso`. The first is discarded, and the remaining 16 form the word, most significant bit first.
- R4: Between two words of a block, `ser_cs` stays low for exactly one serial clock period (HI_CYC+LO_CYC system cycles) before the next lead-in.
- R5: Word k of a block (k counted from 0) is read from address (start_addr + k) mod 2^ADDR_W, and `word_idx` reports k.
- R6: While busy, every low phase of `ser_clk` lasts LO_CYC system cycles and every high phase lasts HI_CYC system cycles. Each transaction begins with a low phase.
- R7: `ser_mosi` changes only while `ser_clk` is low, and `ser_miso` is sampled on the system edge at which `ser_clk` rises.
- R8: Every word read raises `word_vld` for exactly one cycle with `word_data` and `word_idx`, and a block yields exactly `word_count` strobes.
- R9: `done` pulses for one cycle, in the same cycle as the strobe of the final word, and `busy` is low from that cycle on.
- R10: `cksum_ok` is 1 only if the low 16 bits of the sum of all words except the last equal the last word and that sum is non-zero. A single-word block therefore fails.
- R11: When idle, `ser_cs`, `ser_clk` and `ser_mosi` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle block read request |
| start_addr | input | ADDR_W | First word address of the block |
| word_count | input | CNT_W | Number of words to read |
| busy | output | 1 | Block read in progress |
| ser_cs | output | 1 | Device chip select, active high |
| ser_clk | output | 1 | Serial clock to the device |
| ser_mosi | output | 1 | Command and address bits to the device |
| ser_miso | input | 1 | Data bits from the device |
| word_vld | output | 1 | One-cycle strobe for a read word |
| word_data | output | 16 | Word just read |
| word_idx | output | CNT_W | Position of the word within the block |
| done | output | 1 | One-cycle end-of-block pulse |
| cksum_ok | output | 1 | Checksum verdict, valid with done |

## Verification
The assertions assume two things about the device: it changes `ser_miso` only after a falling serial clock edge, and it never drives the link while chip select is low. The bench device model keeps to this by updating its output only on falling edges and returning zero outside a transaction. The checks on the host side, on the other hand, make no assumption about `start`. The stimulus pulses it once while a block is running and once with a zero count, and expects both requests to be ignored.

// File: rtl/eeprd_pkg.sv
package eeprd_pkg;

  localparam int WORD_W  = 16;
  localparam int CMD_LEN = 3;
  // start bit, then read opcode 1,0 ; bit CMD_LEN-1 is sent first
  localparam logic [CMD_LEN-1:0] RD_CMD = 3'b110;

  // Bit driven to the device during a given slot of a word transaction.
  // Slot 0 is the select lead-in, slots 1..CMD_LEN carry the command,
  // the next aw slots carry the address MSB first, the rest drive zero.
  function automatic logic tx_bit(input int unsigned slot,
                                  input logic [15:0] addr,
                                  input int unsigned aw);
    int unsigned pos;
    logic        b;
    b = 1'b0;
    if (slot >= 1 && slot <= CMD_LEN) begin
      pos = CMD_LEN - slot;
      b   = RD_CMD[pos[1:0]];
    end else if (slot > CMD_LEN && slot <= CMD_LEN + aw) begin
      pos = aw - (slot - CMD_LEN);
      b   = addr[pos[3:0]];
    end
    return b;
  endfunction

  function automatic logic [WORD_W-1:0] sum_add(input logic [WORD_W-1:0] acc,
                                                input logic [WORD_W-1:0] word);
    return acc + word;
  endfunction

  function automatic logic cksum_verdict(input logic [WORD_W-1:0] sum,
                                         input logic [WORD_W-1:0] last);
    return (sum == last) && (sum != '0);
  endfunction

endpackage

// File: rtl/eeprd_sclk_gen.sv
module eeprd_sclk_gen #(
  parameter int HI_CYC = 75,
  parameter int LO_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sk_o,
  output logic rise_o,
  output logic slot_end_o
);
  localparam int PER  = HI_CYC + LO_CYC;
  localparam int PH_W = $clog2(PER);
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(LO_CYC - 1);
  localparam logic [PH_W-1:0] PH_HI   = PH_W'(LO_CYC);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PER - 1);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                ph_q <= '0;
    else if (!run)             ph_q <= '0;
    else if (ph_q == PH_LAST)  ph_q <= '0;
    else                       ph_q <= ph_q + 1'b1;
  end

  assign sk_o       = run && (ph_q >= PH_HI);
  assign rise_o     = run && (ph_q == PH_RISE);
  assign slot_end_o = run && (ph_q == PH_LAST);

  // run length of the high phase, kept for the checks below
  logic [15:0] hi_len_q;
  always_ff @(posedge clk) begin
    if (!rst_n)    hi_len_q <= '0;
    else if (sk_o) hi_len_q <= hi_len_q + 1'b1;
    else           hi_len_q <= '0;
  end

  assert_high_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sk_o |-> (hi_len_q < 16'(HI_CYC)));

  assert_rise_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o && run) |=> (sk_o || !run));

  assert_low_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> !sk_o);

endmodule

// File: rtl/eeprd_cksum.sv
module eeprd_cksum #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         add_en,
  input  logic [W-1:0] word,
  output logic [W-1:0] acc_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      acc_o <= '0;
    else if (clr)    acc_o <= '0;
    else if (add_en) acc_o <= eeprd_pkg::sum_add(acc_o, word);
  end

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !add_en) |=> (acc_o == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !add_en) |=> $stable(acc_o));

endmodule

// File: rtl/eeprom_block_reader.sv
module eeprom_block_reader #(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 8,
  parameter int HI_CYC = 75,
  parameter int LO_CYC = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  word_count,
  output logic              busy,
  output logic              ser_cs,
  output logic              ser_clk,
  output logic              ser_mosi,
  input  logic              ser_miso,
  output logic              word_vld,
  output logic [15:0]       word_data,
  output logic [CNT_W-1:0]  word_idx,
  output logic              done,
  output logic              cksum_ok
);
  import eeprd_pkg::*;

  localparam int DATA_FIRST = 1 + CMD_LEN + ADDR_W;
  localparam int DATA_LAST  = DATA_FIRST + WORD_W;   // 17 sampled slots
  localparam int SLOTS      = DATA_LAST + 2;         // plus release slot
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam logic [SLOT_W-1:0] S_DF   = SLOT_W'(DATA_FIRST);
  localparam logic [SLOT_W-1:0] S_DL   = SLOT_W'(DATA_LAST);
  localparam logic [SLOT_W-1:0] S_LAST = SLOT_W'(SLOTS - 1);

  logic              busy_q;
  logic [SLOT_W-1:0] slot_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic [CNT_W-1:0]  idx_q;
  logic [WORD_W-1:0] shreg_q;
  logic [WORD_W-1:0] acc;
  logic              vld_q, done_q, ok_q;
  logic [WORD_W-1:0] data_q;
  logic [CNT_W-1:0]  widx_q;

  // named events
  logic sk, rise_evt, slot_end;
  logic start_ok, in_data, word_end, final_word;

  assign start_ok   = start && !busy_q && (word_count != '0);
  assign in_data    = (slot_q >= S_DF) && (slot_q <= S_DL);
  assign word_end   = slot_end && (slot_q == S_LAST);
  assign final_word = word_end && (left_q == CNT_W'(1));

  eeprd_sclk_gen #(.HI_CYC(HI_CYC), .LO_CYC(LO_CYC)) u_sclk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (busy_q),
    .sk_o       (sk),
    .rise_o     (rise_evt),
    .slot_end_o (slot_end)
  );

  eeprd_cksum #(.W(WORD_W)) u_cksum (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (start_ok),
    .add_en (word_end && !final_word),
    .word   (shreg_q),
    .acc_o  (acc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      slot_q  <= '0;
      addr_q  <= '0;
      left_q  <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      vld_q   <= 1'b0;
      data_q  <= '0;
      widx_q  <= '0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      vld_q  <= 1'b0;
      done_q <= 1'b0;
      if (start_ok) begin
        busy_q <= 1'b1;
        slot_q <= '0;
        addr_q <= start_addr;
        left_q <= word_count;
        idx_q  <= '0;
      end else if (busy_q) begin
        if (rise_evt && in_data)
          shreg_q <= {shreg_q[WORD_W-2:0], ser_miso};
        if (slot_end) begin
          if (slot_q == S_LAST) begin
            vld_q  <= 1'b1;
            data_q <= shreg_q;
            widx_q <= idx_q;
            idx_q  <= idx_q + 1'b1;
            addr_q <= addr_q + 1'b1;
            left_q <= left_q - 1'b1;
            slot_q <= '0;
            if (final_word) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
              ok_q   <= cksum_verdict(acc, shreg_q);
            end
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
      end
    end
  end

  assign busy      = busy_q;
  assign ser_clk   = sk;
  assign ser_cs    = busy_q && (slot_q != S_LAST);
  assign ser_mosi  = busy_q && tx_bit(32'(slot_q), 16'(addr_q), ADDR_W);
  assign word_vld  = vld_q;
  assign word_data = data_q;
  assign word_idx  = widx_q;
  assign done      = done_q;
  assign cksum_ok  = ok_q;

  assert_mosi_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_mosi));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_cs && !ser_clk && !ser_mosi));

  assert_vld_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld);

  assert_done_with_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (word_vld && !busy));

  assert_cs_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_cs) |-> (!ser_clk && busy));

  assert_start_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !word_end) |=> ($stable(addr_q) && $stable(left_q)));

endmodule

// File: tb/eeprom_block_reader_tb_top.sv
module eeprom_block_reader_tb_top;
  localparam int PERIOD = 10;
  localparam int AW     = 6;
  localparam int CW     = 8;
  localparam int HI     = 4;
  localparam int LO     = 2;
  localparam int PER    = HI + LO;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] word_count = '0;
  logic          busy, ser_cs, ser_clk, ser_mosi;
  logic          ser_miso = 1'b0;
  logic          word_vld, done, cksum_ok;
  logic [15:0]   word_data;
  logic [CW-1:0] word_idx;

  int total = 0;
  int bad   = 0;

  always #(PERIOD/2) clk = ~clk;

  eeprom_block_reader #(.ADDR_W(AW), .CNT_W(CW), .HI_CYC(HI), .LO_CYC(LO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .word_count(word_count), .busy(busy), .ser_cs(ser_cs), .ser_clk(ser_clk),
    .ser_mosi(ser_mosi), .ser_miso(ser_miso), .word_vld(word_vld),
    .word_data(word_data), .word_idx(word_idx), .done(done), .cksum_ok(cksum_ok)
  );

  // ---------------- device model ----------------
  logic [15:0] mem [0:63];
  int          dev_state = 0;
  int          dev_cnt = 0;
  int          out_cnt = 0;
  int          zeros = 0;
  int          proto_err = 0;
  logic [1:0]  dev_op;
  logic [5:0]  dev_a;
  logic [15:0] dev_word;
  logic        clk_prev = 1'b0;
  logic [5:0]  addr_log [0:63];
  int          addr_n = 0;

  always @(ser_clk, ser_cs) begin
    if (!ser_cs) begin
      dev_state = 0; dev_cnt = 0; out_cnt = 0; zeros = 0;
      ser_miso = 1'b0;
    end else if (ser_clk && !clk_prev) begin
      case (dev_state)
        0: if (ser_mosi) begin
             if (zeros != 1) proto_err++;
             dev_state = 1; dev_cnt = 0;
           end else zeros++;
        1: begin
             dev_op = {dev_op[0], ser_mosi}; dev_cnt++;
             if (dev_cnt == 2) begin
               if (dev_op != 2'b10) proto_err++;
               dev_state = 2; dev_cnt = 0;
             end
           end
        2: begin
             dev_a = {dev_a[4:0], ser_mosi}; dev_cnt++;
             if (dev_cnt == AW) begin
               dev_state = 3; dev_word = mem[dev_a];
               if (addr_n < 64) addr_log[addr_n] = dev_a;
               addr_n++;
             end
           end
        default: ;
      endcase
    end else if (!ser_clk && clk_prev && dev_state == 3) begin
      if (out_cnt == 0 || out_cnt > 16) ser_miso = 1'b0;
      else ser_miso = dev_word[16 - out_cnt];
      out_cnt++;
    end
    clk_prev = ser_clk;
  end

  // ---------------- monitors (sampled away from the edge) ----------------
  logic [15:0] got_d [0:63];
  logic [CW-1:0] got_i [0:63];
  int   n_got = 0;
  int   done_cnt = 0;
  logic done_vld = 1'b0;
  logic ok_seen = 1'b0;
  int   hi_run = 0, lo_run = 0, gap = 0;
  int   err_hi = 0, err_lo = 0, err_gap = 0, err_mosi = 0;
  logic prev_sk = 1'b0, prev_mosi = 1'b0;

  always @(negedge clk) begin
    if (word_vld) begin
      if (n_got < 64) begin got_d[n_got] = word_data; got_i[n_got] = word_idx; end
      n_got++;
    end
    if (done) begin done_cnt++; done_vld = word_vld; ok_seen = cksum_ok; end
    if (busy) begin
      if (ser_clk) begin
        if (lo_run != 0 && lo_run != LO) err_lo++;
        lo_run = 0; hi_run++;
        if (prev_sk && ser_mosi != prev_mosi) err_mosi++;
      end else begin
        if (hi_run != 0 && hi_run != HI) err_hi++;
        hi_run = 0; lo_run++;
      end
      if (!ser_cs) gap++;
      else begin
        if (gap != 0 && gap != PER) err_gap++;
        gap = 0;
      end
    end else begin
      hi_run = 0; lo_run = 0; gap = 0;
    end
    prev_sk = ser_clk; prev_mosi = ser_mosi;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [AW-1:0] sa, input logic [CW-1:0] cnt);
    n_got = 0; done_cnt = 0; addr_n = 0; done_vld = 1'b0;
    @(negedge clk);
    start = 1'b1; start_addr = sa; word_count = cnt;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_block(input logic [AW-1:0] sa, input logic [CW-1:0] cnt);
    logic [15:0] sum;
    logic        exp_ok;
    logic [AW-1:0] a;
    for (int t = 0; t < 100000 && done_cnt == 0; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R8", n_got, cnt, "word strobes");
    chk("R2", proto_err, 0, "command framing errors");
    sum = '0;
    for (int i = 0; i < cnt; i++) begin
      a = sa + AW'(i);
      chk("R3", got_d[i], mem[a], "word data");
      chk("R5", got_i[i], i, "word index");
      chk("R5", addr_log[i], a, "address sent");
      if (i < cnt - 1) sum = sum + mem[a];
    end
    a = sa + AW'(cnt - 1);
    exp_ok = (sum == mem[a]) && (sum != 16'h0);
    chk("R9", done_cnt, 1, "done pulses");
    chk("R9", done_vld, 1'b1, "done with final strobe");
    chk("R9", busy, 1'b0, "busy after done");
    chk("R10", ok_seen, exp_ok, "checksum verdict");
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk("R11", {ser_cs, ser_clk, ser_mosi}, 3'b000, "idle link");
    chk("R11", {busy, word_vld, done}, 3'b000, "idle status");
  endtask

  task automatic t_basic;
    launch(6'd5, 8'd4);
    finish_block(6'd5, 8'd4);
  endtask

  task automatic t_pass;
    mem[10] = 16'h8001; mem[11] = 16'h7FFE; mem[12] = 16'h1234;
    mem[13] = 16'h8001 + 16'h7FFE + 16'h1234;
    launch(6'd10, 8'd4);
    finish_block(6'd10, 8'd4);
    chk("R10", ok_seen, 1'b1, "matching sum passes");
  endtask

  task automatic t_zero_sum;
    mem[20] = 16'h0; mem[21] = 16'h0; mem[22] = 16'h0;
    launch(6'd20, 8'd3);
    finish_block(6'd20, 8'd3);
    chk("R10", ok_seen, 1'b0, "zero sum fails");
  endtask

  task automatic t_single;
    mem[40] = 16'h0;
    launch(6'd40, 8'd1);
    finish_block(6'd40, 8'd1);
    chk("R10", ok_seen, 1'b0, "single word fails");
  endtask

  task automatic t_wrap;
    launch(6'd62, 8'd4);
    finish_block(6'd62, 8'd4);
  endtask

  task automatic t_busy_start;
    launch(6'd30, 8'd3);
    repeat (50) @(negedge clk);
    start = 1'b1; start_addr = 6'd0; word_count = 8'd9;
    @(negedge clk);
    start = 1'b0;
    finish_block(6'd30, 8'd3);   // R1: second request ignored
  endtask

  task automatic t_zero_count;
    launch(6'd3, 8'd0);
    repeat (20) @(negedge clk);
    chk("R1", busy, 1'b0, "zero count leaves idle");
    chk("R1", ser_cs, 1'b0, "zero count no select");
    chk("R1", n_got, 0, "zero count no strobe");
  endtask

  task automatic t_timing;
    chk("R6", err_hi, 0, "high phase length errors");
    chk("R6", err_lo, 0, "low phase length errors");
    chk("R4", err_gap, 0, "deselect gap errors");
    chk("R7", err_mosi, 0, "mosi changes while clock high");
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h1357) ^ 16'hA5C3;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_pass();
    t_zero_sum();
    t_single();
    t_wrap();
    t_busy_start();
    t_zero_count();
    t_timing();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule